// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This unit sits beside the integer pipeline of a 64-bit processor core and executes the long-latency integer arithmetic. It accepts one command at a time, each carrying two 64-bit operands. The commands are signed or unsigned 32-bit multiply, multiply-accumulate, three-operand multiply, 64-bit multiply, 32-bit divide and 64-bit divide. Results land in a pair of 64-bit result registers, HI and LO. The one exception is the three-operand multiply, which returns its product on a dedicated writeback port and leaves HI and LO untouched.

For the 32-bit multiply family, the unit inspects both operands and picks one of two timing classes. Operands that fit in 16 bits get a short latency and issue interval. All other operands get a longer one. Two commands may overlap in flight. Each command writes its result after a fixed number of cycles, and results always retire in issue order. The issuing pipeline watches `cmd_ready` to know when a new command may be presented. It uses `hold` to stall a HI/LO read until no result is pending.

Divides run on a bit-serial restoring divider and may not be reissued until they complete. A zero divisor raises no trap. It keeps the normal timing and leaves an unspecified value in HI and LO.

Top module: `imac_unit`

## Requirements
- R1: After a synchronous active-low reset, `cmd_ready` is 1, `wb_valid` is 0, nothing is pending, and both HI and LO read back as zero.
- R2: A 32-bit multiply-class command (codes 0, 1, 2) whose operands are both small writes its result 3 cycles after the accepting edge, and the next command can be accepted 2 cycles after it.
- R3: A 32-bit multiply-class command with any operand that is not small writes its result 4 cycles after acceptance, and the next command can be accepted 3 cycles after it.
- R4: An operand is small when `cmd_sign`=1 and its bits 63..15 are all equal, or when `cmd_sign`=0 and its bits 63..16 are all zero.
- R5: Multiply (code 0) forms the 64-bit product of the low 32-bit words, signed when `cmd_sign`=1 and unsigned when it is 0. LO gets the sign-extended low word of the product and HI gets the sign-extended high word.
- R6: Multiply-add (code 1) adds that 64-bit product to {HI[31:0], LO[31:0]} as they stand when the result is written. The sum is split into sign-extended words in the same way as for code 0.
- R7: The three-operand multiply (code 2) raises `wb_valid` for exactly one cycle with `wb_data` equal to the sign-extended low word of the product. HI and LO are left unchanged.
- R8: The 64-bit multiply (code 3) puts the full 128-bit product in HI:LO, with HI holding the upper half. Its result is written 6 cycles after acceptance and the next command can be accepted 5 cycles after it.
- R9: The 32-bit divide (code 4) divides the low words, with the quotient truncated toward zero, and writes the sign-extended quotient to LO and the sign-extended remainder to HI. The remainder takes the dividend's sign. The result is written after 36 cycles, and no command is accepted before then.
- R10: The 64-bit divide (code 5) follows the same rules over the full 64 bits, with a latency and issue interval of 68 cycles.
- R11: While any command is in flight, a read request (`rd_req`=1) gives `hold`=1 and `rd_valid`=0. Otherwise it gives `rd_valid`=1 and `rd_data` equal to HI when `rd_sel`=1 and LO when `rd_sel`=0.
- R12: A divide by zero raises no error. It keeps the normal divide timing, and only the HI/LO contents are unspecified.
- R13: Commands with codes 6 and 7 are never accepted and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Command code (0 mul, 1 mul-add, 2 three-operand mul, 3 64-bit mul, 4 32-bit div, 5 64-bit div) |
| cmd_sign | input | 1 | 1 = signed operands, 0 = unsigned |
| cmd_a | input | 64 | First operand (dividend for divides) |
| cmd_b | input | 64 | Second operand (divisor for divides) |
| rd_req | input | 1 | Request to read HI or LO |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| cmd_ready | output | 1 | A command presented now would be accepted |
| hold | output | 1 | Read interlock: a result is still pending |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 64 | Selected HI or LO value |
| wb_valid | output | 1 | Three-operand multiply result is valid |
| wb_data | output | 64 | Three-operand multiply result |

## Verification
Every result has a due edge counted from the edge that accepted its command. That distance is 3 or 4 edges for the 32-bit multiply family, depending on operand size, 6 for the 64-bit multiply, and 36 or 68 for the divides. Readiness returns 2, 3, 5, 36 or 68 edges after acceptance. The bench model stamps each accepted command with these due edges and keeps an in-order list of pending results. It then predicts `cmd_ready`, `hold`, `rd_valid`, `rd_data`, `wb_valid` and `wb_data` for every cycle and compares them at the falling edge, so a result arriving one cycle early or late shows up as a mismatch. Back-to-back commands are held valid so that acceptance happens at the earliest permitted edge, which checks the issue intervals.

// File: rtl/imac_pkg.sv
// Package: shared command codes, timing constants and helpers for the
// integer multiply-accumulate unit. Assumes a 64-bit datapath.
package imac_pkg;
    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int LAT16  = 3;
    localparam int REP16  = 2;
    localparam int LAT32  = 4;
    localparam int REP32  = 3;
    localparam int LAT64  = 6;
    localparam int REP64  = 5;
    localparam int LATD32 = 36;
    localparam int LATD64 = 68;
    localparam int CNTW   = $clog2(LATD64 + 1);

    typedef enum logic [2:0] {
        OP_MULT  = 3'd0,
        OP_MAD   = 3'd1,
        OP_MULW  = 3'd2,
        OP_DMULT = 3'd3,
        OP_DIV   = 3'd4,
        OP_DDIV  = 3'd5
    } imac_op_e;

    // Sign-extend a 32-bit word to the full register width.
    function automatic logic [XLEN-1:0] sx32(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction
endpackage

// File: rtl/imac_timing.sv
// Module: operand-size detector and timing selector. For a command code it
// returns the cycles until its result is written and the cycles until the
// next command may be accepted. Assumes both operands are presented in full.
module imac_timing
    import imac_pkg::*;
(
    input  logic [2:0]      op,
    input  logic            sgn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            legal,
    output logic [CNTW-1:0] lat,
    output logic [CNTW-1:0] rep
);
    logic small_a, small_b;

    // Small test: upper bits are sign copies (signed) or zero (unsigned).
    always_comb begin
        if (sgn) begin
            small_a = (&a[XLEN-1:15]) | ~(|a[XLEN-1:15]);
            small_b = (&b[XLEN-1:15]) | ~(|b[XLEN-1:15]);
        end else begin
            small_a = ~(|a[XLEN-1:16]);
            small_b = ~(|b[XLEN-1:16]);
        end
    end

    // Pick latency and issue interval for the command code.
    always_comb begin
        legal = 1'b1;
        lat   = '0;
        rep   = '0;
        case (op)
            OP_MULT, OP_MAD, OP_MULW: begin
                lat = (small_a && small_b) ? CNTW'(LAT16) : CNTW'(LAT32);
                rep = (small_a && small_b) ? CNTW'(REP16) : CNTW'(REP32);
            end
            OP_DMULT: begin
                lat = CNTW'(LAT64);
                rep = CNTW'(REP64);
            end
            OP_DIV: begin
                lat = CNTW'(LATD32);
                rep = CNTW'(LATD32);
            end
            OP_DDIV: begin
                lat = CNTW'(LATD64);
                rep = CNTW'(LATD64);
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/imac_divider.sv
// Module: bit-serial restoring divider, one quotient bit per cycle. It runs
// 32 steps for a word divide and 64 for a full divide. Signed operands are
// divided as magnitudes and the signs are fixed on the outputs. Assumes
// start arrives only while idle. A zero divisor gives an unspecified result.
module imac_divider
    import imac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wide,
    input  logic            sgn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            busy,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    logic [XLEN-1:0] na, nb, ma, mb, quo_q, rem_q, dvs_q, qm, rm, qs, rs;
    logic [XLEN:0]   shifted;
    logic [CNTW-1:0] cnt_q;
    logic            neg_a, neg_b, wide_q, nq_q, nr_q;

    // Normalise operands to width and take magnitudes.
    always_comb begin
        na    = wide ? a : (sgn ? sx32(a[HALF-1:0]) : {{HALF{1'b0}}, a[HALF-1:0]});
        nb    = wide ? b : (sgn ? sx32(b[HALF-1:0]) : {{HALF{1'b0}}, b[HALF-1:0]});
        neg_a = sgn & na[XLEN-1];
        neg_b = sgn & nb[XLEN-1];
        ma    = neg_a ? (~na + 1'b1) : na;
        mb    = neg_b ? (~nb + 1'b1) : nb;
    end

    assign shifted = {rem_q, quo_q[XLEN-1]};

    // Load on start, then one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            wide_q <= 1'b0;
            nq_q   <= 1'b0;
            nr_q   <= 1'b0;
        end else if (start) begin
            quo_q  <= wide ? ma : {ma[HALF-1:0], {HALF{1'b0}}};
            rem_q  <= '0;
            dvs_q  <= mb;
            cnt_q  <= wide ? CNTW'(XLEN) : CNTW'(HALF);
            wide_q <= wide;
            nq_q   <= neg_a ^ neg_b;
            nr_q   <= neg_a;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (shifted >= {1'b0, dvs_q}) begin
                rem_q <= XLEN'(shifted - {1'b0, dvs_q});
                quo_q <= {quo_q[XLEN-2:0], 1'b1};
            end else begin
                rem_q <= shifted[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b0};
            end
        end
    end

    // Apply result signs and word-size extension.
    always_comb begin
        qm    = wide_q ? quo_q : {{HALF{1'b0}}, quo_q[HALF-1:0]};
        rm    = wide_q ? rem_q : {{HALF{1'b0}}, rem_q[HALF-1:0]};
        qs    = nq_q ? (~qm + 1'b1) : qm;
        rs    = nr_q ? (~rm + 1'b1) : rm;
        quo_o = wide_q ? qs : sx32(qs[HALF-1:0]);
        rem_o = wide_q ? rs : sx32(rs[HALF-1:0]);
    end

    assign busy = (cnt_q != '0);

    assert_div_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/imac_unit.sv
// Module: top of the integer multiply-accumulate unit. It accepts one
// command per issue interval and parks each product in an in-flight slot
// that counts down to its write edge. Results retire into HI/LO or onto the
// writeback port. Assumes the timing table keeps at most NSLOT results in
// flight and never lets two of them share a write edge.
module imac_unit
    import imac_pkg::*;
#(
    parameter int NSLOT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic            cmd_sign,
    input  logic [63:0]     cmd_a,
    input  logic [63:0]     cmd_b,
    input  logic            rd_req,
    input  logic            rd_sel,
    output logic            cmd_ready,
    output logic            hold,
    output logic            rd_valid,
    output logic [63:0]     rd_data,
    output logic            wb_valid,
    output logic [63:0]     wb_data
);
    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [CNTW-1:0]   lat, rep, rep_q;
    logic              legal, acc, free_ok, wr_any, div_busy, wr_div;
    logic [IW-1:0]     free_idx, wr_idx;
    logic [NSLOT-1:0]  slot_v, wr_vec;
    logic [CNTW-1:0]   slot_cnt [NSLOT];
    imac_op_e          slot_op  [NSLOT];
    logic [XLEN-1:0]   slot_hi  [NSLOT];
    logic [XLEN-1:0]   slot_lo  [NSLOT];
    logic [XLEN-1:0]   hi_q, lo_q, a32, b32, p64, div_q, div_r, new_hi, new_lo;
    logic [2*XLEN-1:0] a128, b128, p128, mad_sum;

    imac_timing u_timing (
        .op(cmd_op), .sgn(cmd_sign), .a(cmd_a), .b(cmd_b),
        .legal(legal), .lat(lat), .rep(rep)
    );

    imac_divider u_div (
        .clk(clk), .rst_n(rst_n),
        .start(acc && (cmd_op == OP_DIV || cmd_op == OP_DDIV)),
        .wide(cmd_op == OP_DDIV), .sgn(cmd_sign), .a(cmd_a), .b(cmd_b),
        .busy(div_busy), .quo_o(div_q), .rem_o(div_r)
    );

    assign cmd_ready = (rep_q <= CNTW'(1));
    assign acc       = cmd_valid && cmd_ready && legal;
    assign hold      = rd_req && (|slot_v);
    assign rd_valid  = rd_req && !(|slot_v);
    assign rd_data   = rd_sel ? hi_q : lo_q;

    // Products formed at issue: word product and full double-width product.
    always_comb begin
        a32  = cmd_sign ? sx32(cmd_a[HALF-1:0]) : {{HALF{1'b0}}, cmd_a[HALF-1:0]};
        b32  = cmd_sign ? sx32(cmd_b[HALF-1:0]) : {{HALF{1'b0}}, cmd_b[HALF-1:0]};
        p64  = a32 * b32;
        a128 = cmd_sign ? {{XLEN{cmd_a[XLEN-1]}}, cmd_a} : {{XLEN{1'b0}}, cmd_a};
        b128 = cmd_sign ? {{XLEN{cmd_b[XLEN-1]}}, cmd_b} : {{XLEN{1'b0}}, cmd_b};
        p128 = a128 * b128;
        case (cmd_op)
            OP_MULT:  begin new_hi = sx32(p64[XLEN-1:HALF]); new_lo = sx32(p64[HALF-1:0]); end
            OP_DMULT: begin new_hi = p128[2*XLEN-1:XLEN];    new_lo = p128[XLEN-1:0];      end
            default:  begin new_hi = '0;                     new_lo = p64;                 end
        endcase
    end

    // Find a free slot and the slot whose result is due this edge.
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        wr_any   = 1'b0;
        wr_idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            wr_vec[i] = slot_v[i] && (slot_cnt[i] == CNTW'(1));
            if (!slot_v[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
            if (wr_vec[i]) begin
                wr_any = 1'b1;
                wr_idx = IW'(i);
            end
        end
        wr_div  = wr_any && (slot_op[wr_idx] == OP_DIV || slot_op[wr_idx] == OP_DDIV);
        mad_sum = {{XLEN{1'b0}}, hi_q[HALF-1:0], lo_q[HALF-1:0]} + {{XLEN{1'b0}}, slot_lo[wr_idx]};
    end

    // Issue-interval counter driving cmd_ready.
    always_ff @(posedge clk) begin
        if (!rst_n)            rep_q <= '0;
        else if (acc)          rep_q <= rep;
        else if (rep_q != '0)  rep_q <= rep_q - 1'b1;
    end

    // One in-flight slot per generate index: load on issue, count to write.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[g]   <= 1'b0;
                slot_cnt[g] <= '0;
                slot_op[g]  <= OP_MULT;
                slot_hi[g]  <= '0;
                slot_lo[g]  <= '0;
            end else if (acc && free_idx == IW'(g)) begin
                slot_v[g]   <= 1'b1;
                slot_cnt[g] <= lat;
                slot_op[g]  <= imac_op_e'(cmd_op);
                slot_hi[g]  <= new_hi;
                slot_lo[g]  <= new_lo;
            end else if (slot_v[g]) begin
                slot_cnt[g] <= slot_cnt[g] - 1'b1;
                if (slot_cnt[g] == CNTW'(1)) slot_v[g] <= 1'b0;
            end
        end
    end

    // Retire the due result into HI/LO or onto the writeback port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= 1'b0;
            if (wr_any) begin
                case (slot_op[wr_idx])
                    OP_MAD: begin
                        hi_q <= sx32(mad_sum[XLEN-1:HALF]);
                        lo_q <= sx32(mad_sum[HALF-1:0]);
                    end
                    OP_MULW: begin
                        wb_valid <= 1'b1;
                        wb_data  <= sx32(slot_lo[wr_idx][HALF-1:0]);
                    end
                    OP_DIV, OP_DDIV: begin
                        hi_q <= div_r;
                        lo_q <= div_q;
                    end
                    default: begin
                        hi_q <= slot_hi[wr_idx];
                        lo_q <= slot_lo[wr_idx];
                    end
                endcase
            end
        end
    end

    assert_issue_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !cmd_ready);
    assert_slot_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> free_ok);
    assert_single_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
    assert_hilo_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ($stable(hi_q) && $stable(lo_q)));
    assert_wb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);
    assert_div_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div |-> !div_busy);
endmodule

// File: tb/imac_unit_tb_top.sv
// Bench: a behavioural reference model keeps an in-order queue of pending
// results stamped with their due edge. Every DUT output is compared with
// the model at each falling edge.
module imac_unit_tb_top;
    typedef struct {
        int          due;
        logic [2:0]  op;
        logic [63:0] hi;
        logic [63:0] lo;
        bit          unk;
    } pend_t;

    logic        clk = 0, rst_n = 0, cmd_valid = 0, cmd_sign = 0;
    logic [2:0]  cmd_op = 0;
    logic [63:0] cmd_a = 0, cmd_b = 0;
    logic        rd_req = 1, rd_sel = 0;
    logic        cmd_ready, hold, rd_valid, wb_valid;
    logic [63:0] rd_data, wb_data;

    int n_cmp = 0, n_bad = 0, edge_n = 0, next_ok = 0, acc_cnt = 0;
    bit armed = 0, done = 0, m_unk = 0, m_wbv = 0;
    logic [63:0] m_hi = 0, m_lo = 0, m_wbd = 0;
    string cur_req = "R1";
    pend_t pend[$];

    imac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sign(cmd_sign), .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_req(rd_req),
        .rd_sel(rd_sel), .cmd_ready(cmd_ready), .hold(hold), .rd_valid(rd_valid),
        .rd_data(rd_data), .wb_valid(wb_valid), .wb_data(wb_data)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic bit is_small(input bit s, input logic [63:0] v);
        if (s) return ($signed(v) >= -64'sd32768) && ($signed(v) <= 64'sd32767);
        return v < 64'd65536;
    endfunction

    function automatic logic [63:0] mul_word(input bit s, input logic [63:0] a, b);
        logic [63:0] ua, ub;
        if (s) return longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
        ua = {32'b0, a[31:0]};
        ub = {32'b0, b[31:0]};
        return ua * ub;
    endfunction

    // Compute the result a command leaves behind, per R5..R10 and R12.
    task automatic exec(input logic [2:0] op, input bit s, input logic [63:0] a, b,
                        output pend_t p);
        logic [63:0] w;
        logic signed [127:0] sa, sb;
        logic [127:0] ua, ub, pr;
        p.op = op; p.unk = 0; p.hi = 0; p.lo = 0;
        case (op)
            3'd0: begin w = mul_word(s, a, b); p.hi = sx(w[63:32]); p.lo = sx(w[31:0]); end
            3'd1, 3'd2: p.lo = mul_word(s, a, b);
            3'd3: begin
                if (s) begin sa = $signed(a); sb = $signed(b); pr = sa * sb; end
                else begin ua = {64'b0, a}; ub = {64'b0, b}; pr = ua * ub; end
                p.hi = pr[127:64]; p.lo = pr[63:0];
            end
            3'd4: begin
                if (b[31:0] == 0) p.unk = 1;
                else if (s) begin
                    p.lo = sx($signed(a[31:0]) / $signed(b[31:0]));
                    p.hi = sx($signed(a[31:0]) % $signed(b[31:0]));
                end else begin
                    p.lo = sx(a[31:0] / b[31:0]);
                    p.hi = sx(a[31:0] % b[31:0]);
                end
            end
            default: begin
                if (b == 0) p.unk = 1;
                else if (s) begin
                    p.lo = $signed(a) / $signed(b);
                    p.hi = $signed(a) % $signed(b);
                end else begin
                    p.lo = a / b;
                    p.hi = a % b;
                end
            end
        endcase
    endtask

    // Reference model step at every rising edge.
    always @(posedge clk) begin
        pend_t p;
        logic [63:0] sum;
        int lat, rep;
        edge_n++;
        m_wbv = 0;
        if (!rst_n) begin
            pend.delete();
            m_hi = 0; m_lo = 0; m_unk = 0; next_ok = 0; m_wbd = 0;
        end else begin
            if (pend.size() > 0 && pend[0].due == edge_n) begin
                p = pend.pop_front();
                if (p.op == 3'd2) begin
                    m_wbv = 1; m_wbd = sx(p.lo[31:0]);
                end else if (p.op == 3'd1) begin
                    sum = {m_hi[31:0], m_lo[31:0]} + p.lo;
                    m_hi = sx(sum[63:32]); m_lo = sx(sum[31:0]);
                end else begin
                    m_hi = p.hi; m_lo = p.lo; m_unk = p.unk;
                end
            end
            if (cmd_valid && edge_n >= next_ok && cmd_op <= 3'd5) begin
                case (cmd_op)
                    3'd3: begin lat = 6; rep = 5; end
                    3'd4: begin lat = 36; rep = 36; end
                    3'd5: begin lat = 68; rep = 68; end
                    default: begin
                        if (is_small(cmd_sign, cmd_a) && is_small(cmd_sign, cmd_b)) begin
                            lat = 3; rep = 2;
                        end else begin
                            lat = 4; rep = 3;
                        end
                    end
                endcase
                exec(cmd_op, cmd_sign, cmd_a, cmd_b, p);
                p.due = edge_n + lat;
                pend.push_back(p);
                next_ok = edge_n + rep;
                acc_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (edge %0d)", tag, what, act, exp, edge_n);
        end
    endtask

    // Compare every output against the model at the falling edge.
    always @(negedge clk) begin
        bit ev, eh;
        if (armed) begin
            ev = (edge_n + 1 >= next_ok);
            eh = pend.size() > 0;
            chk(cmd_ready === ev, cur_req, "cmd_ready", 64'(cmd_ready), 64'(ev));
            chk(hold === (rd_req && eh), "R11", "hold", 64'(hold), 64'(rd_req && eh));
            chk(rd_valid === (rd_req && !eh), "R11", "rd_valid", 64'(rd_valid), 64'(rd_req && !eh));
            if (rd_req && !eh && !m_unk)
                chk(rd_data === (rd_sel ? m_hi : m_lo), cur_req, rd_sel ? "HI" : "LO",
                    rd_data, rd_sel ? m_hi : m_lo);
            chk(wb_valid === m_wbv, "R7", "wb_valid", 64'(wb_valid), 64'(m_wbv));
            if (m_wbv) chk(wb_data === m_wbd, "R7", "wb_data", wb_data, m_wbd);
        end
    end

    // Alternate the read selection so both HI and LO are observed.
    always @(posedge clk) begin
        #3 rd_sel = ~rd_sel;
    end

    task automatic issue(input string tag, input logic [2:0] op, input bit s,
                         input logic [63:0] a, input logic [63:0] b);
        int start;
        cur_req = tag;
        cmd_op = op; cmd_sign = s; cmd_a = a; cmd_b = b; cmd_valid = 1;
        start = acc_cnt;
        while (acc_cnt == start) begin
            @(posedge clk);
            #2;
        end
        cmd_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (edge %0d)", edge_n);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1; armed = 1;
        idle(3);                                                      // R1 reset state
        issue("R5", 3'd0, 1, -64'sd7, 64'd12000);                     // R5 signed small
        idle(6);
        issue("R5", 3'd0, 0, 64'hFFFF_FFFF_1234_5678, 64'h9ABC_DEF0); // R5 unsigned large
        issue("R3", 3'd0, 1, 64'hFFFF_FFFF_8765_4321, 64'd3);         // R3 back-to-back
        idle(6);
        issue("R2", 3'd1, 1, 64'd100, 64'd200);                       // R2 MAD chain
        issue("R2", 3'd1, 1, -64'sd300, 64'd50);
        issue("R6", 3'd1, 0, 64'h7FFF_FFFF, 64'h7FFF_FFFF);           // R6 large MAD
        idle(6);
        issue("R4", 3'd0, 1, 64'd32767, -64'sd32768);                 // R4 signed edge small
        issue("R4", 3'd0, 1, 64'd32768, 64'd2);                       // R4 just above
        issue("R4", 3'd0, 0, 64'd65535, 64'd65535);                   // R4 unsigned edge small
        issue("R4", 3'd0, 0, -64'sd1, 64'd1);                         // R4 unsigned all ones
        issue("R4", 3'd0, 1, -64'sd1, -64'sd1);                       // R4 signed all ones small
        idle(6);
        issue("R7", 3'd2, 1, -64'sd9, 64'd9);                         // R7 small
        issue("R7", 3'd2, 1, 64'd123456, 64'd654321);                 // R7 large
        issue("R7", 3'd0, 0, 64'd5, 64'd6);
        idle(6);
        issue("R8", 3'd3, 1, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_1234); // R8
        issue("R8", 3'd3, 0, -64'sd1, -64'sd1);
        issue("R2", 3'd0, 1, 64'd3, 64'd4);                           // short after long
        idle(8);
        issue("R9", 3'd4, 1, -64'sd100, 64'd7);                       // R9 signed
        issue("R9", 3'd4, 0, 64'hFFFF_FFF0, 64'd7);                   // R9 unsigned
        issue("R9", 3'd0, 1, 64'd2, 64'd2);
        idle(6);
        issue("R10", 3'd5, 1, -64'sd1000000000000, 64'd3);            // R10 signed
        issue("R10", 3'd5, 0, 64'hF000_0000_0000_0003, 64'h1_0000_0001); // R10 unsigned
        issue("R10", 3'd5, 1, 64'd77, -64'sd5);
        issue("R12", 3'd4, 1, 64'd55, 64'd0);                         // R12 zero divisor
        issue("R12", 3'd0, 1, 64'd11, 64'd13);
        idle(8);
        cur_req = "R13";                                              // R13 illegal codes
        cmd_op = 3'd6; cmd_valid = 1; idle(4);
        cmd_op = 3'd7; idle(4);
        cmd_valid = 0; idle(2);
        issue("R13", 3'd1, 1, 64'd2, 64'd3);
        idle(8);
        summary();
    end
endmodule